// File: doc/BRIEF.md
# Serial Receive Buffer with Fill Trigger and Idle Timeout

This block sits between an already-deserialised serial receiver and the processor's register interface. Each received byte is stored in a 16-entry circular buffer. The processor takes bytes out one at a time by strobing a data-register read, and it can see how many bytes are waiting through a 5-bit fill count.

A ready flag does not rise when the first byte arrives. It rises when the fill level reaches a programmable threshold of 1, 4, 8 or 14 bytes. A receive interrupt request goes with the flag and is gated by an enable input. If fewer bytes than the threshold have arrived and the line then goes quiet, an idle timer raises the flag anyway. The timer runs for 15 elementary time units, and the number of clock cycles in one unit is a parameter. This way a short message never sits unnoticed in the buffer.

A control-register write carries two things: a 2-bit threshold code in bits 7:6 and a flush command in bit 1. The receive-enable and interrupt-enable bits are decoded elsewhere and arrive as plain inputs.

Top module: `serial_rx_buffer`

## Requirements
- R1: Bytes leave the buffer in the order they arrived. The read and write positions wrap from entry 15 back to entry 0. `fill_cnt` reports 0 to 16 on 5 bits.
- R2: A control write loads the threshold from `ctl_wdata[7:6]`. Code 0 gives 1 byte, code 1 gives 4, code 2 gives 8 and code 3 gives 14.
- R3: When an accepted byte brings the fill level to the threshold or above, `rdf` is set on the next edge. If `irq_en` is high, `rx_irq` is set on the same edge and any pending idle timeout is cancelled. `rx_irq` is never high while `rdf` is low.
- R4: An accepted byte that leaves the level below the threshold restarts the idle timer. If no further byte is accepted, `rdf` (and `rx_irq` when `irq_en` is high) rises exactly 15 × ETU_CYCLES cycles after the edge that stored the byte.
- R5: A `rd_pop` strobe with a non-empty buffer removes the oldest byte. That byte appears on `rd_data` after the next edge and the count drops by one. If the new count is below the threshold, `rdf` and `rx_irq` are cleared.
- R6: A `rd_pop` strobe with an empty buffer puts 0 on `rd_data` and leaves the count and flags unchanged.
- R7: A byte offered while 16 entries are held is discarded. The count stays at 16 and the stored bytes are unchanged.
- R8: A control write with bit 1 set empties the buffer. It also zeroes the count, clears `rdf` and `rx_irq`, and cancels the idle timer. A byte or pop offered in the same cycle is ignored.
- R9: Incoming bytes are accepted only while `rx_en` is high.
- R10: A push and a pop in the same cycle, with the buffer neither empty nor full, are both performed and the count is unchanged.
- R11: After reset the count is 0, `rdf`, `rx_irq` and `rd_data` are 0, and the threshold code is 0.
- R12: `rx_irq` is low in every cycle that follows a cycle with `irq_en` low. Taking `irq_en` low does not clear `rdf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable; bytes are stored only while high |
| irq_en | input | 1 | Receive interrupt enable |
| ctl_wr | input | 1 | Control-register write strobe |
| ctl_wdata | input | 8 | Control write data: [7:6] threshold code, [1] flush |
| in_valid | input | 1 | A received byte is offered this cycle |
| in_data | input | 8 | Received byte |
| rd_pop | input | 1 | Data-register read strobe |
| rd_data | output | 8 | Byte returned by the last read strobe |
| fill_cnt | output | 5 | Number of bytes held (0 to 16) |
| rdf | output | 1 | Receive-data-ready flag |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
A corrupted read or write position shows on the very next pop as a byte out of order or a repeated byte. A count that drifts shows at once on `fill_cnt`. It also shows within one push or pop as `rdf` switching at the wrong level, because the threshold compare uses that same count. A fault in the idle timer shows only as `rdf` rising one or more cycles off the 15-unit mark, so the timeout is checked on the exact cycle on both sides of expiry, including after a restart. Discard at full and the empty-read value each show within one cycle through `fill_cnt` and `rd_data`.

// File: rtl/srb_pkg.sv
package srb_pkg;

  localparam int CTL_W         = 8;
  localparam int CTL_TRIG_LSB  = 6;
  localparam int CTL_FLUSH_BIT = 1;

  typedef enum logic [1:0] {
    TRG_1  = 2'd0,
    TRG_4  = 2'd1,
    TRG_8  = 2'd2,
    TRG_14 = 2'd3
  } trig_code_e;

  function automatic int unsigned trig_level(input trig_code_e code);
    case (code)
      TRG_1:   return 1;
      TRG_4:   return 4;
      TRG_8:   return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/srb_store.sv
module srb_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req,
  output logic          acc_wr,
  output logic          acc_rd,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nxt,
  output logic [DW-1:0] rd_data
);

  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, empty;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + AW'(1);
  endfunction

  assign full   = (cnt_q == CNT_FULL);
  assign empty  = (cnt_q == '0);
  assign acc_wr = wr_req && !full && !clr;
  assign acc_rd = rd_req && !empty && !clr;

  always_comb begin
    if (clr) cnt_nxt = '0;
    else     cnt_nxt = cnt_q + CW'(acc_wr) - CW'(acc_rd);
  end

  // storage array: no reset, single write port, registered read
  always_ff @(posedge clk) begin
    if (acc_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (acc_rd) rd_data <= mem[rd_ptr];
    else if (rd_req) rd_data <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (acc_wr) wr_ptr <= bump(wr_ptr);
      if (acc_rd) rd_ptr <= bump(rd_ptr);
      cnt_q <= cnt_nxt;
    end
  end

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_FULL);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (full && wr_req && !rd_req && !clr) |=> (cnt_q == CNT_FULL));

  assert_empty_read_R6: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_req) |=> (rd_data == '0));

  assert_flush_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));

  assert_pair_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_req && rd_req && !full && !empty && !clr) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/srb_timer.sv
module srb_timer #(
  parameter int ETU_CYCLES = 4,
  parameter int ETU_LIMIT  = 15,
  localparam int PW = (ETU_CYCLES > 1) ? $clog2(ETU_CYCLES) : 1,
  localparam int EW = (ETU_LIMIT  > 1) ? $clog2(ETU_LIMIT)  : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic cancel,
  output logic expire
);

  localparam logic [PW-1:0] PRE_LAST = PW'(ETU_CYCLES - 1);
  localparam logic [EW-1:0] ETU_LAST = EW'(ETU_LIMIT - 1);

  logic          armed;
  logic [PW-1:0] pre_q;
  logic [EW-1:0] etu_q;
  logic          at_end;

  assign at_end = armed && (pre_q == PRE_LAST) && (etu_q == ETU_LAST);
  assign expire = at_end && !restart && !cancel;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      pre_q <= '0;
      etu_q <= '0;
    end else if (restart) begin
      armed <= 1'b1;
      pre_q <= '0;
      etu_q <= '0;
    end else if (cancel || at_end) begin
      armed <= 1'b0;
      pre_q <= '0;
      etu_q <= '0;
    end else if (armed) begin
      if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        etu_q <= etu_q + EW'(1);
      end else begin
        pre_q <= pre_q + PW'(1);
      end
    end
  end

  assert_one_shot_R4: assert property (@(posedge clk) disable iff (rst)
    expire |=> !expire);

  assert_restart_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    restart |=> !expire);

endmodule

// File: rtl/srb_flag.sv
module srb_flag #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          acc_wr,
  input  logic          acc_rd,
  input  logic [CW-1:0] cnt_nxt,
  input  logic [CW-1:0] trig_lvl,
  input  logic          irq_en,
  input  logic          tmo,
  output logic          rdf,
  output logic          irq,
  output logic          tmr_restart,
  output logic          tmr_cancel
);

  logic reach, drop;

  assign reach       = acc_wr && (cnt_nxt >= trig_lvl);
  assign drop        = acc_rd && (cnt_nxt < trig_lvl);
  assign tmr_restart = acc_wr && !reach;
  assign tmr_cancel  = clr || (reach && irq_en);

  always_ff @(posedge clk) begin
    if (rst || clr)          rdf <= 1'b0;
    else if (reach || tmo)   rdf <= 1'b1;
    else if (drop)           rdf <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || clr || !irq_en) irq <= 1'b0;
    else if (reach || tmo)     irq <= 1'b1;
    else if (drop)             irq <= 1'b0;
  end

  assert_irq_needs_flag_R3: assert property (@(posedge clk) disable iff (rst)
    irq |-> rdf);

  assert_reach_sets_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && !clr && (cnt_nxt >= trig_lvl)) |=> rdf);

  assert_irq_gate_R12: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq);

  assert_drop_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && !acc_wr && !tmo && (cnt_nxt < trig_lvl)) |=> !rdf);

endmodule

// File: rtl/serial_rx_buffer.sv
module serial_rx_buffer
  import srb_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int DW         = 8,
  parameter int ETU_CYCLES = 4,
  parameter int ETU_LIMIT  = 15,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_en,
  input  logic             irq_en,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  input  logic             rd_pop,
  output logic [DW-1:0]    rd_data,
  output logic [CW-1:0]    fill_cnt,
  output logic             rdf,
  output logic             rx_irq
);

  trig_code_e    trig_q;
  logic [CW-1:0] trig_lvl;
  logic          flush;
  logic          acc_wr, acc_rd;
  logic [CW-1:0] cnt_nxt;
  logic          tmo, tmr_restart, tmr_cancel;
  logic          ctl_unused;

  assign flush      = ctl_wr && ctl_wdata[CTL_FLUSH_BIT];
  assign trig_lvl   = CW'(trig_level(trig_q));
  assign ctl_unused = ^{ctl_wdata[5:2], ctl_wdata[0]};

  always_ff @(posedge clk) begin
    if (rst)         trig_q <= TRG_1;
    else if (ctl_wr) trig_q <= trig_code_e'(ctl_wdata[CTL_TRIG_LSB +: 2]);
  end

  srb_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk     (clk),
    .rst     (rst),
    .clr     (flush),
    .wr_req  (in_valid && rx_en),
    .wr_data (in_data),
    .rd_req  (rd_pop),
    .acc_wr  (acc_wr),
    .acc_rd  (acc_rd),
    .cnt_q   (fill_cnt),
    .cnt_nxt (cnt_nxt),
    .rd_data (rd_data)
  );

  srb_timer #(.ETU_CYCLES(ETU_CYCLES), .ETU_LIMIT(ETU_LIMIT)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (tmr_restart),
    .cancel  (tmr_cancel),
    .expire  (tmo)
  );

  srb_flag #(.CW(CW)) u_flag (
    .clk         (clk),
    .rst         (rst),
    .clr         (flush),
    .acc_wr      (acc_wr),
    .acc_rd      (acc_rd),
    .cnt_nxt     (cnt_nxt),
    .trig_lvl    (trig_lvl),
    .irq_en      (irq_en),
    .tmo         (tmo),
    .rdf         (rdf),
    .irq         (rx_irq),
    .tmr_restart (tmr_restart),
    .tmr_cancel  (tmr_cancel)
  );

  assert_rx_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && !flush) |=> (fill_cnt <= $past(fill_cnt)));

  assert_flush_flags_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!rdf && !rx_irq));

endmodule

// File: tb/sim_serial_rx_buffer.sv
module sim_serial_rx_buffer;

  localparam int ETU = 4;
  localparam int TMO = 15 * ETU;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_en = 1'b0, irq_en = 1'b0, ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic       in_valid = 1'b0, rd_pop = 1'b0;
  logic [7:0] in_data = '0;
  logic [7:0] rd_data;
  logic [4:0] fill_cnt;
  logic       rdf, rx_irq;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_rx_buffer #(.ETU_CYCLES(ETU)) u0 (
    .clk(clk), .rst(rst), .rx_en(rx_en), .irq_en(irq_en),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .in_valid(in_valid), .in_data(in_data), .rd_pop(rd_pop),
    .rd_data(rd_data), .fill_cnt(fill_cnt), .rdf(rdf), .rx_irq(rx_irq)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    in_valid = 1'b1; in_data = b; step(); in_valid = 1'b0;
  endtask

  task automatic pop();
    rd_pop = 1'b1; step(); rd_pop = 1'b0;
  endtask

  task automatic ctl(input logic [7:0] v);
    ctl_wr = 1'b1; ctl_wdata = v; step(); ctl_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 count", fill_cnt, 0);
    chk("R11 rdf", rdf, 0);
    chk("R11 irq", rx_irq, 0);
    chk("R11 rd_data", rd_data, 0);
  endtask

  // threshold 1 (reset code 0), fill to 16, overflow, drain, wrap
  task automatic t_order_wrap();
    rx_en = 1; irq_en = 0;
    push(8'h11);
    chk("R11 R2 code0 level1 rdf", rdf, 1);
    chk("R3 irq gated off", rx_irq, 0);
    for (int i = 1; i < 16; i++) push(8'hA0 + 8'(i));
    chk("R1 count 16", fill_cnt, 16);
    push(8'hFF);
    chk("R7 count stays 16", fill_cnt, 16);
    pop();
    chk("R1 first byte", rd_data, 8'h11);
    for (int i = 1; i < 16; i++) begin
      pop();
      chk("R1 R7 order", rd_data, 8'hA0 + i);
    end
    chk("R5 empty count", fill_cnt, 0);
    chk("R5 rdf cleared", rdf, 0);
    for (int i = 0; i < 3; i++) push(8'h50 + 8'(i));
    for (int i = 0; i < 3; i++) begin
      pop();
      chk("R1 wrap order", rd_data, 8'h50 + i);
    end
  endtask

  task automatic t_trigger(input int code, input int lvl);
    irq_en = 1;
    ctl(8'((code << 6) | 2));
    for (int i = 0; i < lvl - 1; i++) push(8'(i + 1));
    chk("R2 below threshold", rdf, 0);
    push(8'hEE);
    chk("R2 R3 rdf at threshold", rdf, 1);
    chk("R3 irq at threshold", rx_irq, 1);
    pop();
    chk("R5 count after pop", fill_cnt, lvl - 1);
    chk("R5 rdf cleared", rdf, 0);
    chk("R5 irq cleared", rx_irq, 0);
  endtask

  task automatic t_timeout();
    irq_en = 1;
    ctl(8'h42);
    push(8'h7A);
    repeat (TMO - 1) step();
    chk("R4 before expiry", rdf, 0);
    step();
    chk("R4 rdf at expiry", rdf, 1);
    chk("R4 irq at expiry", rx_irq, 1);
    chk("R4 count", fill_cnt, 1);
    irq_en = 0; step();
    chk("R12 irq dropped", rx_irq, 0);
    chk("R12 rdf kept", rdf, 1);
    irq_en = 1;
    pop();
    chk("R5 data", rd_data, 8'h7A);
    chk("R5 rdf cleared", rdf, 0);
    push(8'h01);
    repeat (30) step();
    push(8'h02);
    repeat (TMO - 1) step();
    chk("R4 restarted not yet", rdf, 0);
    step();
    chk("R4 restarted expiry", rdf, 1);
  endtask

  task automatic t_flush_empty();
    ctl(8'h02);
    chk("R8 count zero", fill_cnt, 0);
    chk("R8 rdf zero", rdf, 0);
    chk("R8 irq zero", rx_irq, 0);
    push(8'h33);
    pop();
    chk("R6 setup data", rd_data, 8'h33);
    pop();
    chk("R6 empty read zero", rd_data, 0);
    chk("R6 count unchanged", fill_cnt, 0);
    chk("R6 rdf unchanged", rdf, 0);
  endtask

  task automatic t_pair_gate();
    ctl(8'h82);
    push(8'h61); push(8'h62); push(8'h63);
    in_valid = 1; in_data = 8'h64; rd_pop = 1; step();
    in_valid = 0; rd_pop = 0;
    chk("R10 count unchanged", fill_cnt, 3);
    chk("R10 popped oldest", rd_data, 8'h61);
    rx_en = 0;
    push(8'h99);
    chk("R9 disabled push ignored", fill_cnt, 3);
    rx_en = 1;
    for (int i = 0; i < 3; i++) begin
      pop();
      chk("R10 R9 order", rd_data, 8'h62 + i);
    end
    push(8'h70); push(8'h71);
    in_valid = 1; in_data = 8'h72; ctl_wr = 1; ctl_wdata = 8'h02; step();
    in_valid = 0; ctl_wr = 0;
    chk("R8 flush beats push", fill_cnt, 0);
  endtask

  initial begin
    repeat (3) step();
    rst = 0;
    t_reset();
    t_order_wrap();
    t_trigger(1, 4);
    t_trigger(2, 8);
    t_trigger(3, 14);
    t_timeout();
    t_flush_empty();
    t_pair_gate();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule